// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block is a half-duplex asynchronous serial transceiver for a smart card contact interface. It moves 8-bit characters over a single pair of serial lines. Each frame on the line is a low start bit, eight data bits, one parity bit and a single high stop bit. One format input selects the convention, and the convention sets three things together: bit order, data polarity and parity sense. In direct convention the data is sent least significant bit first, at true levels, with even parity. In inverse convention it is sent most significant bit first, at complemented levels, with odd parity.

The CPU side is register style. A write strobe loads a holding register. When transmit is enabled, the holding register hands its character to a shift register. A read strobe frees the receive buffer. Three configuration inputs set the bit time: a source-clock select, a prescaler exponent and an 8-bit rate divisor. The receiver checks every character. It flags parity, stop-bit and overrun faults. When a character fails its parity check, the block reports this to the far end by pulling its own transmit line low for one bit time. Two single-cycle pulses mark the end of a transmitted frame and the arrival of a received character.

Top module: `sc_uart`

## Requirements
- R1: In direct convention (`inverse_fmt`=0) the transmit line carries, in this order, a low start bit, data bits 0 through 7 at true levels, a parity bit equal to the XOR of the eight data bits (even parity), and a high stop bit. The line idles high.
- R2: In inverse convention (`inverse_fmt`=1) the transmitted data bits go out from bit 7 down to bit 0, each at the complement of its value. The logical parity bit makes the count of ones over data plus parity odd, and it is sent complemented. Start is low and stop is high.
- R3: A character written with `tx_wr` while `tx_en` is 0 is held, and the transmit line stays high. Transmission starts only once `tx_en` is 1 and the holding register is loaded.
- R4: `tx_done` pulses for one cycle when the shift register finishes a stop bit. A second character written while the first is shifting goes out directly after it, and each frame gives its own pulse.
- R5: In direct convention a received frame is decoded with bit 0 first. At the mid-stop sample the character moves into `rx_rdata`, and `rx_done` pulses for one cycle.
- R6: In inverse convention a received frame is decoded with the first data bit as bit 7, and each bit is complemented.
- R7: A start bit counts only if the line is still low half a bit time after the falling edge. A shorter low glitch gives no character and no `rx_done`.
- R8: When a received character fails its parity check, `err_parity` is set and `txd` is driven low for one bit time (16 oversample ticks). The low period starts at the stop-bit sample point.
- R9: A received stop bit sampled low sets `err_framing`. Both `err_framing` and `err_parity` take the result of each completed character.
- R10: If bit 7 of a new character is sampled while the buffer is still unread, `err_overrun` is set. The buffer keeps the earlier character and `rx_done` does not pulse. `rx_rd` clears `err_overrun` and frees the buffer.
- R11: `err_summary` is the OR of `err_overrun`, `err_framing` and `err_parity`.
- R12: While `rx_en` is 0, line activity produces no `rx_done`.
- R13: One bit lasts 16×(`rate_div`+1) source clocks. The source is the system clock when `src_sel`=0, the system clock divided by 8 when `src_sel`=1, and the clock divided by 2×`presc_n` when `src_sel`=2 (undivided if `presc_n`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| inverse_fmt | input | 1 | 0 direct convention, 1 inverse convention |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| src_sel | input | 2 | Bit-rate source: 0 clock, 1 clock/8, 2 prescaled, 3 treated as 0 |
| presc_n | input | 4 | Prescaler exponent n, divide by 2n |
| rate_div | input | 8 | Rate divisor m |
| tx_wr | input | 1 | Load `tx_wdata` into the holding register |
| tx_wdata | input | 8 | Character to send |
| rx_rd | input | 1 | Buffer read strobe |
| rx_rdata | output | 8 | Received character buffer |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_done | output | 1 | Transmit frame complete pulse |
| rx_done | output | 1 | Receive character complete pulse |
| err_overrun | output | 1 | Overrun flag |
| err_framing | output | 1 | Stop-bit fault flag |
| err_parity | output | 1 | Parity fault flag |
| err_summary | output | 1 | OR of the three fault flags |

## Verification
`txd` is registered, so each transmitted bit appears one clock after the shifter changes. The transmit monitor first finds the falling start edge, then samples every bit at its middle, half a bit time from the edge and one full bit time apart after that, so a phase error of a few clocks has no effect. A received character is due two synchronizer clocks plus one register after the mid-stop sample. The receive monitor therefore reacts to `rx_done` at the falling clock edge and never waits for a fixed cycle count. The fault flags and the low nack period are read only after the driven frame has ended plus a few clocks, and the nack is measured as a count of low cycles over a window that covers the whole stop bit.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;

  localparam int OVS = 16;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_DIV8 = 2'd1,
    SRC_PRE  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2
  } rx_state_e;

  function automatic logic [7:0] bit_rev(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[7-i];
    return r;
  endfunction

  // Line-level frame, element 0 leaves first.
  function automatic logic [10:0] line_frame(input logic [7:0] d, input logic inv);
    logic [7:0] ord;
    logic [7:0] lvl;
    ord = inv ? bit_rev(d) : d;
    lvl = inv ? ~ord : ord;
    // even parity on true levels equals the complemented odd parity
    return {1'b1, ^d, lvl, 1'b0};
  endfunction

endpackage

// File: rtl/sc_baud.sv
module sc_baud
  import sc_uart_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel,
  input  logic [PRE_W-1:0] presc_n,
  input  logic [DIV_W-1:0] rate_div,
  output logic             tick
);
  localparam int PC_W = PRE_W + 1;

  logic [2:0]       c8;
  logic [PC_W-1:0]  cp;
  logic [DIV_W-1:0] cm;
  logic             ce_pre;
  logic             ce;

  always_comb begin
    ce_pre = (presc_n == '0) || (cp >= ({presc_n, 1'b0} - PC_W'(1)));
    case (src_sel)
      SRC_DIV8: ce = (c8 == 3'd7);
      SRC_PRE:  ce = ce_pre;
      default:  ce = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c8   <= '0;
      cp   <= '0;
      cm   <= '0;
      tick <= 1'b0;
    end else begin
      c8   <= c8 + 3'd1;
      cp   <= ce_pre ? '0 : cp + PC_W'(1);
      tick <= 1'b0;
      if (ce) begin
        if (cm >= rate_div) begin
          cm   <= '0;
          tick <= 1'b1;
        end else begin
          cm <= cm + DIV_W'(1);
        end
      end
    end
  end

  // R13: with a divisor above zero, ticks never come on back-to-back cycles
  a_r13_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (rate_div != '0 && $stable(rate_div)) |-> !(tick && $past(tick)));

endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       inverse_fmt,
  input  logic       tx_en,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       nack_go,
  output logic       txd,
  output logic       tx_done
);
  localparam int TW = $clog2(OVS);

  logic [7:0]    hold;
  logic          hold_full;
  logic          busy;
  logic [10:0]   sh;
  logic [TW-1:0] tcnt;
  logic [3:0]    bitn;
  logic          nack_act;
  logic [TW-1:0] ncnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sh        <= '1;
      tcnt      <= '0;
      bitn      <= '0;
      nack_act  <= 1'b0;
      ncnt      <= '0;
      txd       <= 1'b1;
      tx_done   <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (!busy && hold_full && tx_en) begin
        sh        <= line_frame(hold, inverse_fmt);
        busy      <= 1'b1;
        hold_full <= 1'b0;
        tcnt      <= '0;
        bitn      <= '0;
      end else if (busy && tick) begin
        if (tcnt == TW'(OVS - 1)) begin
          tcnt <= '0;
          sh   <= {1'b1, sh[10:1]};
          if (bitn == 4'd10) begin
            busy    <= 1'b0;
            tx_done <= 1'b1;
          end else begin
            bitn <= bitn + 4'd1;
          end
        end else begin
          tcnt <= tcnt + TW'(1);
        end
      end
      if (wr) begin
        hold      <= wdata;
        hold_full <= 1'b1;
      end
      if (nack_go) begin
        nack_act <= 1'b1;
        ncnt     <= '0;
      end else if (nack_act && tick) begin
        if (ncnt == TW'(OVS - 1)) nack_act <= 1'b0;
        else                      ncnt     <= ncnt + TW'(1);
      end
      txd <= (busy ? sh[0] : 1'b1) & ~nack_act;
    end
  end

  // R1: an idle shifter with no nack leaves the line high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!busy && !nack_act) |=> txd);
  // R8: an active nack forces the line low
  a_r8_nack_low: assert property (@(posedge clk) disable iff (rst)
    nack_act |=> !txd);
  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_uart_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       inverse_fmt,
  input  logic       rx_en,
  input  logic       rxd,
  input  logic       rd,
  output logic [7:0] rdata,
  output logic       rx_done,
  output logic       ovr,
  output logic       ferr,
  output logic       perr,
  output logic       nack_go
);
  localparam int TW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  logic [SYNC_N-1:0] sync;
  logic              rxs;
  rx_state_e         st;
  logic [TW-1:0]     tcnt;
  logic [3:0]        bitn;
  logic [7:0]        sh;
  logic              pbit;
  logic              full;
  logic              ovr_cur;
  logic [7:0]        decoded;
  logic              bad_par;

  assign rxs     = sync[SYNC_N-1];
  assign decoded = inverse_fmt ? ~bit_rev(sh) : sh;
  // the same check covers both conventions on line levels
  assign bad_par = (^sh) ^ pbit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync    <= '1;
      st      <= RX_IDLE;
      tcnt    <= '0;
      bitn    <= '0;
      sh      <= '0;
      pbit    <= 1'b0;
      full    <= 1'b0;
      ovr_cur <= 1'b0;
      rdata   <= '0;
      rx_done <= 1'b0;
      ovr     <= 1'b0;
      ferr    <= 1'b0;
      perr    <= 1'b0;
      nack_go <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      nack_go <= 1'b0;
      sync    <= {sync[SYNC_N-2:0], rxd};
      if (rd) begin
        full <= 1'b0;
        ovr  <= 1'b0;
      end
      if (!rx_en) begin
        st <= RX_IDLE;
      end else begin
        case (st)
          RX_IDLE: if (!rxs) begin
            st   <= RX_START;
            tcnt <= '0;
          end
          RX_START: if (tick) begin
            if (tcnt == TW'(HALF - 1)) begin
              tcnt <= '0;
              if (!rxs) begin
                st      <= RX_DATA;
                bitn    <= '0;
                ovr_cur <= 1'b0;
              end else begin
                st <= RX_IDLE;
              end
            end else begin
              tcnt <= tcnt + TW'(1);
            end
          end
          RX_DATA: if (tick) begin
            if (tcnt == TW'(OVS - 1)) begin
              tcnt <= '0;
              bitn <= bitn + 4'd1;
              if (bitn < 4'd8) begin
                sh <= {rxs, sh[7:1]};
                if (bitn == 4'd7 && full) begin
                  ovr     <= 1'b1;
                  ovr_cur <= 1'b1;
                end
              end else if (bitn == 4'd8) begin
                pbit <= rxs;
              end else begin
                st      <= RX_IDLE;
                ferr    <= !rxs;
                perr    <= bad_par;
                nack_go <= bad_par;
                if (!ovr_cur) begin
                  rdata   <= decoded;
                  full    <= 1'b1;
                  rx_done <= 1'b1;
                end
              end
            end else begin
              tcnt <= tcnt + TW'(1);
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R5: the receive completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);
  // R12: a disabled receiver never reports a character
  a_r12_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_done);
  // R10: an unread buffer is never overwritten
  a_r10_keep_unread: assert property (@(posedge clk) disable iff (rst)
    ($past(full) && !$past(rd)) |-> $stable(rdata));

endmodule

// File: rtl/sc_uart.sv
module sc_uart
  import sc_uart_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inverse_fmt,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [1:0]       src_sel,
  input  logic [PRE_W-1:0] presc_n,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             tx_wr,
  input  logic [7:0]       tx_wdata,
  input  logic             rx_rd,
  output logic [7:0]       rx_rdata,
  input  logic             rxd,
  output logic             txd,
  output logic             tx_done,
  output logic             rx_done,
  output logic             err_overrun,
  output logic             err_framing,
  output logic             err_parity,
  output logic             err_summary
);
  logic tick;
  logic nack_go;

  sc_baud #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_baud (
    .clk(clk), .rst(rst), .src_sel(src_sel), .presc_n(presc_n),
    .rate_div(rate_div), .tick(tick)
  );

  sc_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick), .inverse_fmt(inverse_fmt),
    .tx_en(tx_en), .wr(tx_wr), .wdata(tx_wdata), .nack_go(nack_go),
    .txd(txd), .tx_done(tx_done)
  );

  sc_rx #(.SYNC_N(2)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .inverse_fmt(inverse_fmt),
    .rx_en(rx_en), .rxd(rxd), .rd(rx_rd), .rdata(rx_rdata),
    .rx_done(rx_done), .ovr(err_overrun), .ferr(err_framing),
    .perr(err_parity), .nack_go(nack_go)
  );

  assign err_summary = err_overrun | err_framing | err_parity;

endmodule

// File: tb/test_sc_uart.sv
module test_sc_uart;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inverse_fmt = 1'b0;
  logic       tx_en = 1'b0;
  logic       rx_en = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [3:0] presc_n = 4'd0;
  logic [7:0] rate_div = 8'd0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_wdata = 8'd0;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_rdata;
  logic       rxd = 1'b1;
  logic       txd, tx_done, rx_done;
  logic       err_overrun, err_framing, err_parity, err_summary;

  int checks = 0;
  int fails = 0;
  int bit_clks = 16;
  int tx_cnt = 0;
  int rx_cnt = 0;
  logic mon_tx = 1'b0;
  logic [10:0] tx_q[$];
  string       tx_tag[$];
  logic [7:0]  rx_q[$];

  always #10 clk = ~clk;

  sc_uart i_sc_uart (
    .clk(clk), .rst(rst), .inverse_fmt(inverse_fmt), .tx_en(tx_en),
    .rx_en(rx_en), .src_sel(src_sel), .presc_n(presc_n), .rate_div(rate_div),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .rxd(rxd), .txd(txd), .tx_done(tx_done), .rx_done(rx_done),
    .err_overrun(err_overrun), .err_framing(err_framing),
    .err_parity(err_parity), .err_summary(err_summary)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // expected line levels, element 0 first, from R1/R2
  function automatic logic [10:0] mk(input logic [7:0] d, input logic inv,
                                     input logic flip_par, input logic stop);
    logic [10:0] f;
    logic p;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = inv ? ~d[7-i] : d[i];
    p = inv ? ~(^d) : (^d);
    f[9] = (inv ? ~p : p) ^ flip_par;
    f[10] = stop;
    return f;
  endfunction

  task automatic send_tx(input logic [7:0] d, input string tag);
    tx_q.push_back(mk(d, inverse_fmt, 1'b0, 1'b1));
    tx_tag.push_back(tag);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wait_tx(input int n);
    while (tx_cnt < n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic drive_rx(input logic [10:0] f);
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (bit_clks - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic rd_pulse();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  always @(negedge clk) if (!rst && tx_done) tx_cnt++;

  // receive scoreboard
  always @(negedge clk) begin
    if (!rst && rx_done) begin
      rx_cnt++;
      if (rx_q.size() == 0) chk(1'b0, "R5/R12 unexpected rx_done", rx_rdata, 0);
      else begin
        logic [7:0] e;
        e = rx_q.pop_front();
        chk(rx_rdata == e, "R5/R6 received character", rx_rdata, e);
      end
    end
  end

  // transmit scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_tx && !rst && txd == 1'b0) begin
        logic [10:0] got;
        logic [10:0] e;
        string t;
        repeat (bit_clks / 2) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < 11; i++) begin
          repeat (bit_clks) @(negedge clk);
          got[i] = txd;
        end
        if (tx_q.size() == 0) chk(1'b0, "R3 unexpected frame", got, 0);
        else begin
          e = tx_q.pop_front();
          t = tx_tag.pop_front();
          chk(got == e, t, got, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1 watchdog expired", 0, 1);
    report();
  end

  initial begin
    int lows;
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    chk(txd == 1'b1, "R1 idle line after reset", txd, 1);
    chk(err_summary == 1'b0, "R11 flags clear after reset", err_summary, 0);
    chk(rx_done == 1'b0 && tx_done == 1'b0, "R4 no pulses after reset", rx_done, 0);

    mon_tx = 1'b1;
    tx_en = 1'b1;
    rx_en = 1'b1;
    // R1 and R4 back-to-back
    send_tx(8'hA5, "R1 direct frame A5");
    repeat (20) @(negedge clk);
    send_tx(8'h3C, "R4 queued frame 3C");
    wait_tx(2);
    chk(tx_cnt == 2, "R4 one pulse per frame", tx_cnt, 2);
    // R2
    inverse_fmt = 1'b1;
    send_tx(8'h3B, "R2 inverse frame 3B");
    wait_tx(3);
    inverse_fmt = 1'b0;
    // R3
    tx_en = 1'b0;
    @(negedge clk); tx_wr = 1'b1; tx_wdata = 8'h81;
    @(negedge clk); tx_wr = 1'b0;
    lows = 0;
    repeat (300) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0, "R3 line high while disabled", lows, 0);
    chk(tx_cnt == 3, "R3 no completion while disabled", tx_cnt, 3);
    tx_q.push_back(mk(8'h81, 1'b0, 1'b0, 1'b1));
    tx_tag.push_back("R3 held frame 81");
    tx_en = 1'b1;
    wait_tx(4);
    // R13 rates
    rate_div = 8'd1; bit_clks = 32;
    send_tx(8'h96, "R13 divisor 1");
    wait_tx(5);
    src_sel = 2'd1; bit_clks = 256;
    send_tx(8'h4E, "R13 clock/8");
    wait_tx(6);
    src_sel = 2'd2; presc_n = 4'd3; rate_div = 8'd0; bit_clks = 96;
    send_tx(8'hD2, "R13 prescaler 2n");
    wait_tx(7);
    src_sel = 2'd0; presc_n = 4'd0; bit_clks = 16;
    repeat (20) @(negedge clk);
    chk(tx_q.size() == 0, "R1 all frames seen", tx_q.size(), 0);
    mon_tx = 1'b0;

    // R5 direct receive
    rx_q.push_back(8'h47);
    drive_rx(mk(8'h47, 1'b0, 1'b0, 1'b1));
    chk(err_summary == 1'b0, "R5 clean character no flags", err_summary, 0);
    rd_pulse();
    // R6 inverse receive
    inverse_fmt = 1'b1;
    rx_q.push_back(8'hC2);
    drive_rx(mk(8'hC2, 1'b1, 1'b0, 1'b1));
    chk(err_parity == 1'b0, "R6 inverse parity accepted", err_parity, 0);
    rd_pulse();
    inverse_fmt = 1'b0;
    // R7 glitch
    base = rx_cnt;
    @(negedge clk); rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    chk(rx_cnt == base, "R7 glitch rejected", rx_cnt, base);
    rx_q.push_back(8'h6D);
    drive_rx(mk(8'h6D, 1'b0, 1'b0, 1'b1));
    chk(rx_cnt == base + 1, "R7 next frame received", rx_cnt, base + 1);
    rd_pulse();
    // R8 parity error and nack
    rx_q.push_back(8'h10);
    lows = 0;
    fork
      drive_rx(mk(8'h10, 1'b0, 1'b1, 1'b1));
      begin
        repeat (11 * 16 + 40) begin @(negedge clk); if (!txd) lows++; end
      end
    join
    chk(err_parity == 1'b1, "R8 parity flag", err_parity, 1);
    chk(lows == 16, "R8 nack low one bit time", lows, 16);
    chk(err_summary == 1'b1, "R11 summary on parity", err_summary, 1);
    rd_pulse();
    // R9 framing
    rx_q.push_back(8'h55);
    drive_rx(mk(8'h55, 1'b0, 1'b0, 1'b0));
    chk(err_framing == 1'b1, "R9 framing flag", err_framing, 1);
    chk(err_parity == 1'b0, "R9 parity flag follows character", err_parity, 0);
    rd_pulse();
    rx_q.push_back(8'h0F);
    drive_rx(mk(8'h0F, 1'b0, 1'b0, 1'b1));
    chk(err_framing == 1'b0, "R9 flag updated by good character", err_framing, 0);
    rd_pulse();
    // R10 overrun
    rx_q.push_back(8'h11);
    drive_rx(mk(8'h11, 1'b0, 1'b0, 1'b1));
    base = rx_cnt;
    drive_rx(mk(8'h22, 1'b0, 1'b0, 1'b1));
    chk(err_overrun == 1'b1, "R10 overrun flag", err_overrun, 1);
    chk(rx_cnt == base, "R10 no rx_done on overrun", rx_cnt, base);
    chk(rx_rdata == 8'h11, "R10 buffer kept", rx_rdata, 8'h11);
    chk(err_summary == 1'b1, "R11 summary on overrun", err_summary, 1);
    rd_pulse();
    @(negedge clk);
    chk(err_overrun == 1'b0, "R10 read clears overrun", err_overrun, 0);
    chk(err_summary == 1'b0, "R11 summary clear", err_summary, 0);
    // R12 disabled receiver
    rx_en = 1'b0;
    base = rx_cnt;
    drive_rx(mk(8'h99, 1'b0, 1'b0, 1'b1));
    chk(rx_cnt == base, "R12 disabled receiver silent", rx_cnt, base);
    rx_en = 1'b1;
    repeat (10) @(negedge clk);
    report();
  end
endmodule